// File: doc/BRIEF.md
# Three-wire serial EEPROM slave

This block models a small nonvolatile memory that a host reaches over a three-wire synchronous link made of a select line, a serial clock and a data-in line, with a data-out line back to the host. The chip select, serial clock and data input are oversampled in the system clock domain. Each frame opens with a logic-1 start bit, followed by a two-bit operation code and a fixed-length address field. From these the block decodes read, single-location write and erase, whole-array erase and fill, and the pair of commands that opens and closes the programming gate.

The 2048-bit store is viewed as 128 sixteen-bit words when the organization strap is high, or as 256 bytes when it is low. The address field always carries one padding bit at its top that is clocked but ignored. Programming runs as a self-timed cycle whose length is a parameter. While that cycle runs, and until the next start bit, the data-out line reports busy (0) or ready (1) whenever select is high.

Top module: `eep_serial_slave`

## Requirements
- R1: After reset, data out is not driven and programming is disabled; reset does not change the stored contents.
- R2: Serial clock rising edges with data in at 0 before the start bit are ignored. Dropping select in the middle of a frame abandons it without any change to memory.
- R3: Read (opcode 10) with select held high drives data out. A 0 dummy bit appears after the last address bit, then the location's value, most significant bit first, one bit per rising serial clock edge.
- R4: In 16-bit mode the address field is 8 bits, with the top bit ignored. Write (opcode 01) takes 16 data bits, most significant first, and replaces the word without a prior erase.
- R5: In 8-bit mode (strap low) the address field is 9 bits, with the top bit ignored, and data is 8 bits. Byte address bit 0 selects the low (0) or high (1) byte of 16-bit word address[7:1].
- R6: Erase (opcode 11) sets every bit of the addressed location to 1: the whole word in 16-bit mode, only the byte in 8-bit mode.
- R7: With opcode 00, top address bits 10 set the whole array to 1s. Top bits 01 fill every location with the supplied data; in 8-bit mode every byte receives it.
- R8: With opcode 00, top address bits 11 enable programming and 00 disable it. While disabled, write, erase and both whole-array commands leave memory unchanged and no status is shown.
- R9: Read works whether programming is enabled or disabled.
- R10: An accepted program command makes the busy window last exactly PROG_CYCLES clocks. With select high, data out shows 0 while busy and 1 once ready; with select low it is not driven.
- R11: Start bits arriving while busy are ignored and the status stays on data out. The first start bit after ready clears the status display.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from host |
| di_i | input | 1 | Serial data from host |
| org_i | input | 1 | Organization strap: 1 = 16-bit words, 0 = bytes |
| do_o | output | 1 | Serial data / status to host (0 when not driven) |
| do_oe_o | output | 1 | Output enable for do_o (0 = high impedance) |

## Verification
The bench builds the block with its default 2048-bit store and 16-bit word, but shortens PROG_CYCLES to 64. A whole busy window then fits inside a few serial bits. The bench can probe busy status, drop select in the middle of the window, and send ignored start bits before ready, and then watch the first accepted start bit clear the status. Because the default geometry is kept, it reaches the last word (0x7F) and the last byte (0x1FF), with the padding bit set in both modes.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_DONE
  } eep_state_t;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_ERASE = 2'b11;
  localparam logic [1:0] OP_MISC  = 2'b00;

  // sub-codes carried in the two top address-field bits when opcode is OP_MISC
  localparam logic [1:0] SUB_GATE_ON  = 2'b11;
  localparam logic [1:0] SUB_GATE_OFF = 2'b00;
  localparam logic [1:0] SUB_FILL_1   = 2'b10;
  localparam logic [1:0] SUB_FILL_D   = 2'b01;

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[g] <= 1'b0;
        s2_q[g] <= 1'b0;
        s3_q[g] <= 1'b0;
      end else begin
        s1_q[g] <= d_i[g];
        s2_q[g] <= s1_q[g];
        s3_q[g] <= s2_q[g];
      end
    end
    assign rise_o[g] = s2_q[g] & ~s3_q[g];
  end

  assign q_o = s2_q;
endmodule

// File: rtl/eep_timer.sv
module eep_timer #(
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == CW'(PROG_CYCLES - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int WORDS  = 128,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     commit_i,
  input  logic                     all_i,
  input  logic                     worg_i,
  input  logic [$clog2(WORDS)-1:0] waddr_i,
  input  logic                     wbsel_i,
  input  logic [WORD_W-1:0]        wdata_i,
  input  logic                     rorg_i,
  input  logic [$clog2(WORDS)-1:0] raddr_i,
  input  logic                     rbsel_i,
  output logic [WORD_W-1:0]        rword_o
);
  localparam int AW = $clog2(WORDS);
  localparam int BW = WORD_W / 2;

  logic [BW-1:0] lane_rd [2];

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [BW-1:0] mem [WORDS];
    logic          lane_en;

    assign lane_en = all_i | worg_i | (wbsel_i == 1'(l));

    always_ff @(posedge clk) begin
      if (commit_i && lane_en) begin
        for (int w = 0; w < WORDS; w++) begin
          if (all_i || (waddr_i == AW'(w))) begin
            mem[w] <= wdata_i[l*BW +: BW];
          end
        end
      end
    end

    assign lane_rd[l] = mem[raddr_i];
  end

  assign rword_o = rorg_i ? {lane_rd[1], lane_rd[0]}
                          : {{BW{1'b0}}, (rbsel_i ? lane_rd[1] : lane_rd[0])};
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int WORDS  = 128,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_i,
  input  logic                     sk_rise_i,
  input  logic                     di_i,
  input  logic                     org_i,
  input  logic                     busy_i,
  input  logic [WORD_W-1:0]        rword_i,
  output logic [$clog2(WORDS)-1:0] raddr_o,
  output logic                     rbsel_o,
  output logic                     do_bit_o,
  output logic                     rd_on_o,
  output logic                     st_mode_o,
  output logic                     we_en_o,
  output logic                     quiet_o,
  output logic                     start_o,
  output logic                     p_all_o,
  output logic                     p_org_o,
  output logic [$clog2(WORDS)-1:0] p_waddr_o,
  output logic                     p_bsel_o,
  output logic [WORD_W-1:0]        p_data_o
);
  localparam int AW16 = $clog2(WORDS);
  localparam int AW8  = AW16 + 1;
  localparam int AFW  = AW8 + 1;
  localparam int BW   = WORD_W / 2;
  localparam int CW   = $clog2(WORD_W + 1);

  eep_state_t      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [1:0]      opc_q, opc_d;
  logic [AFW-1:0]  af_q, af_d;
  logic [WORD_W-1:0] dsh_q, dsh_d, rsh_q, rsh_d, pdat_q, pdat_d;
  logic            do_q, do_d, we_q, we_d, st_q, st_d, start_q, start_d;
  logic            pall_q, pall_d, porg_q, porg_d, pbs_q, pbs_d;
  logic [AW16-1:0] pwa_q, pwa_d;

  logic [AFW-1:0]    af_sh;
  logic [WORD_W-1:0] ds_sh;
  logic [CW-1:0]     alen, dlen;
  logic [1:0]        top2;

  assign af_sh = {af_q[AFW-2:0], di_i};
  assign ds_sh = {dsh_q[WORD_W-2:0], di_i};
  assign alen  = org_i ? CW'(AFW - 1) : CW'(AFW);
  assign dlen  = org_i ? CW'(WORD_W) : CW'(BW);
  assign top2  = org_i ? af_sh[AFW-2 -: 2] : af_sh[AFW-1 -: 2];

  assign raddr_o = org_i ? af_sh[AW16-1:0] : af_sh[AW8-1:1];
  assign rbsel_o = ~org_i & af_sh[0];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    opc_d   = opc_q;
    af_d    = af_q;
    dsh_d   = dsh_q;
    rsh_d   = rsh_q;
    pdat_d  = pdat_q;
    do_d    = do_q;
    we_d    = we_q;
    st_d    = st_q;
    start_d = 1'b0;
    pall_d  = pall_q;
    porg_d  = porg_q;
    pbs_d   = pbs_q;
    pwa_d   = pwa_q;

    if (!cs_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (sk_rise_i) begin
      case (state_q)
        ST_IDLE: begin
          if (di_i && !busy_i) begin
            state_d = ST_OPC;
            cnt_d   = '0;
            st_d    = 1'b0;
            af_d    = '0;
          end
        end
        ST_OPC: begin
          opc_d = {opc_q[0], di_i};
          if (cnt_q == CW'(1)) begin
            state_d = ST_ADDR;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_ADDR: begin
          af_d = af_sh;
          if (cnt_q == alen - 1'b1) begin
            cnt_d   = '0;
            state_d = ST_DONE;
            pwa_d   = raddr_o;
            pbs_d   = rbsel_o;
            porg_d  = org_i;
            pall_d  = 1'b0;
            pdat_d  = '1;
            case (opc_q)
              OP_READ: begin
                state_d = ST_READ;
                do_d    = 1'b0;
                rsh_d   = org_i ? rword_i : {rword_i[BW-1:0], {BW{1'b0}}};
              end
              OP_WRITE: state_d = ST_DATA;
              OP_ERASE: begin
                if (we_q) begin
                  start_d = 1'b1;
                  st_d    = 1'b1;
                end
              end
              default: begin
                case (top2)
                  SUB_GATE_ON:  we_d = 1'b1;
                  SUB_GATE_OFF: we_d = 1'b0;
                  SUB_FILL_1: begin
                    pall_d = 1'b1;
                    if (we_q) begin
                      start_d = 1'b1;
                      st_d    = 1'b1;
                    end
                  end
                  default: begin
                    pall_d  = 1'b1;
                    state_d = ST_DATA;
                  end
                endcase
              end
            endcase
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          dsh_d = ds_sh;
          if (cnt_q == dlen - 1'b1) begin
            state_d = ST_DONE;
            pdat_d  = org_i ? ds_sh : {ds_sh[BW-1:0], ds_sh[BW-1:0]};
            if (we_q) begin
              start_d = 1'b1;
              st_d    = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_READ: begin
          do_d  = rsh_q[WORD_W-1];
          rsh_d = {rsh_q[WORD_W-2:0], 1'b0};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      opc_q   <= '0;
      af_q    <= '0;
      dsh_q   <= '0;
      rsh_q   <= '0;
      pdat_q  <= '0;
      do_q    <= 1'b0;
      we_q    <= 1'b0;
      st_q    <= 1'b0;
      start_q <= 1'b0;
      pall_q  <= 1'b0;
      porg_q  <= 1'b0;
      pbs_q   <= 1'b0;
      pwa_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      opc_q   <= opc_d;
      af_q    <= af_d;
      dsh_q   <= dsh_d;
      rsh_q   <= rsh_d;
      pdat_q  <= pdat_d;
      do_q    <= do_d;
      we_q    <= we_d;
      st_q    <= st_d;
      start_q <= start_d;
      pall_q  <= pall_d;
      porg_q  <= porg_d;
      pbs_q   <= pbs_d;
      pwa_q   <= pwa_d;
    end
  end

  assign do_bit_o  = do_q;
  assign rd_on_o   = (state_q == ST_READ);
  assign st_mode_o = st_q;
  assign we_en_o   = we_q;
  assign quiet_o   = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign start_o   = start_q;
  assign p_all_o   = pall_q;
  assign p_org_o   = porg_q;
  assign p_waddr_o = pwa_q;
  assign p_bsel_o  = pbs_q;
  assign p_data_o  = pdat_q;
endmodule

// File: rtl/eep_serial_slave.sv
module eep_serial_slave #(
  parameter int MEM_BITS    = 2048,
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic org_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int WORDS = MEM_BITS / WORD_W;
  localparam int AW    = $clog2(WORDS);

  logic          rst_s1_q, rst_s_q;
  logic [2:0]    pin_s, pin_rise;
  logic          cs_s, di_s, sk_rise;
  logic          busy, commit, we_en, ctrl_quiet;
  logic          do_bit, rd_on, st_mode, start;
  logic          p_all, p_org, p_bsel, rbsel;
  logic [AW-1:0] p_waddr, raddr;
  logic [WORD_W-1:0] p_data, rword;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s_q  <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s_q  <= rst_s1_q;
    end
  end

  eep_sync #(.N(3)) u_sync (
    .clk    (clk),
    .rst_n  (rst_s_q),
    .d_i    ({cs_i, sk_i, di_i}),
    .q_o    (pin_s),
    .rise_o (pin_rise)
  );

  assign cs_s    = pin_s[2];
  assign di_s    = pin_s[0];
  assign sk_rise = pin_rise[1];

  eep_ctrl #(.WORDS(WORDS), .WORD_W(WORD_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s_q),
    .cs_i      (cs_s),
    .sk_rise_i (sk_rise),
    .di_i      (di_s),
    .org_i     (org_i),
    .busy_i    (busy),
    .rword_i   (rword),
    .raddr_o   (raddr),
    .rbsel_o   (rbsel),
    .do_bit_o  (do_bit),
    .rd_on_o   (rd_on),
    .st_mode_o (st_mode),
    .we_en_o   (we_en),
    .quiet_o   (ctrl_quiet),
    .start_o   (start),
    .p_all_o   (p_all),
    .p_org_o   (p_org),
    .p_waddr_o (p_waddr),
    .p_bsel_o  (p_bsel),
    .p_data_o  (p_data)
  );

  eep_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_s_q),
    .start_i (start),
    .busy_o  (busy),
    .done_o  (commit)
  );

  eep_array #(.WORDS(WORDS), .WORD_W(WORD_W)) u_array (
    .clk      (clk),
    .commit_i (commit),
    .all_i    (p_all),
    .worg_i   (p_org),
    .waddr_i  (p_waddr),
    .wbsel_i  (p_bsel),
    .wdata_i  (p_data),
    .rorg_i   (org_i),
    .raddr_i  (raddr),
    .rbsel_i  (rbsel),
    .rword_o  (rword)
  );

  assign do_oe_o = cs_s & (st_mode | rd_on);
  assign do_o    = do_oe_o & (st_mode ? ~busy : do_bit);
endmodule

// File: rtl/eep_serial_chk.sv
module eep_serial_chk #(
  parameter int PROG_CYCLES = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic cs_i,
  input logic do_oe,
  input logic busy,
  input logic we_en,
  input logic commit,
  input logic quiet
);
  logic [31:0] busy_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len_q <= '0;
    else        busy_len_q <= busy ? busy_len_q + 1'b1 : '0;
  end

  // R10: select low two samples ago leaves data out undriven
  p_hiz_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs_i, 2) |-> !do_oe);

  // R8: a program window only opens while the gate is enabled
  p_gate_prog_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> we_en);

  // R10: the busy window spans exactly PROG_CYCLES clocks
  p_busy_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len_q == 32'(PROG_CYCLES)));

  // R7: memory commit lines up with the end of busy
  p_commit_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $fell(busy));

  // R11: no frame decoding proceeds while busy
  p_quiet_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> quiet);
endmodule

bind eep_serial_slave eep_serial_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs_i   (cs_i),
  .do_oe  (do_oe_o),
  .busy   (busy),
  .we_en  (we_en),
  .commit (commit),
  .quiet  (ctrl_quiet)
);

// File: tb/sim_eep_serial_slave.sv
module sim_eep_serial_slave;
  localparam int PROG = 64;

  localparam logic [2:0] K_RD = 3'd0, K_WR = 3'd1, K_ER = 3'd2, K_EN = 3'd3,
                         K_DS = 3'd4, K_EA = 3'd5, K_WA = 3'd6;

  // {req, kind, org, addr, data, expected}
  localparam int NT = 24;
  localparam logic [48:0] TBL [NT] = '{
    {4'd8, K_EN, 1'b1, 9'h000, 16'h0000, 16'h0000},  // R8 gate on
    {4'd7, K_EA, 1'b1, 9'h000, 16'h0000, 16'h0000},  // R7 fill ones
    {4'd7, K_RD, 1'b1, 9'h005, 16'h0000, 16'hFFFF},  // R7
    {4'd7, K_RD, 1'b0, 9'h0FE, 16'h0000, 16'h00FF},  // R7
    {4'd4, K_WR, 1'b1, 9'h085, 16'h1234, 16'h0000},  // R4 pad bit set
    {4'd3, K_RD, 1'b1, 9'h005, 16'h0000, 16'h1234},  // R3
    {4'd5, K_RD, 1'b0, 9'h10A, 16'h0000, 16'h0034},  // R5 pad bit set
    {4'd5, K_RD, 1'b0, 9'h00B, 16'h0000, 16'h0012},  // R5
    {4'd5, K_WR, 1'b0, 9'h00B, 16'h00AB, 16'h0000},  // R5
    {4'd5, K_RD, 1'b1, 9'h005, 16'h0000, 16'hAB34},  // R5
    {4'd6, K_ER, 1'b0, 9'h00A, 16'h0000, 16'h0000},  // R6 byte erase
    {4'd6, K_RD, 1'b1, 9'h005, 16'h0000, 16'hABFF},  // R6
    {4'd6, K_ER, 1'b1, 9'h005, 16'h0000, 16'h0000},  // R6 word erase
    {4'd6, K_RD, 1'b1, 9'h005, 16'h0000, 16'hFFFF},  // R6
    {4'd7, K_WA, 1'b1, 9'h000, 16'h5AC3, 16'h0000},  // R7 fill data
    {4'd7, K_RD, 1'b1, 9'h07F, 16'h0000, 16'h5AC3},  // R7
    {4'd7, K_RD, 1'b1, 9'h000, 16'h0000, 16'h5AC3},  // R7
    {4'd7, K_WA, 1'b0, 9'h000, 16'h0096, 16'h0000},  // R7 byte fill
    {4'd7, K_RD, 1'b1, 9'h040, 16'h0000, 16'h9696},  // R7
    {4'd8, K_DS, 1'b1, 9'h000, 16'h0000, 16'h0000},  // R8 gate off
    {4'd8, K_WR, 1'b1, 9'h003, 16'h0000, 16'h0000},  // R8 blocked write
    {4'd9, K_RD, 1'b1, 9'h003, 16'h0000, 16'h9696},  // R9 read while off
    {4'd8, K_EA, 1'b0, 9'h000, 16'h0000, 16'h0000},  // R8 blocked fill
    {4'd8, K_RD, 1'b0, 9'h1FF, 16'h0000, 16'h0096}   // R8
  };

  logic clk, rst_n, cs, sk, di, org, dout, doe;
  int nchk, nerr;
  bit done;

  eep_serial_slave #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .org_i(org),
    .do_o(dout), .do_oe_o(doe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    di = b; tick(3); sk = 1'b1; tick(4); sk = 1'b0; tick(3);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic cs_hi; cs = 1'b1; tick(4); endtask
  task automatic cs_lo; cs = 1'b0; di = 1'b0; tick(6); endtask

  function automatic int afl(input logic o); return o ? 8 : 9; endfunction

  task automatic instr(input logic o, input logic [2:0] k, input logic [8:0] a,
                       input logic [15:0] d);
    int n;
    n = afl(o);
    org = o;
    cs_hi;
    bit_out(1'b1);
    case (k)
      K_WR: begin send(2'b01, 2); send(32'(a), n); send(32'(d), o ? 16 : 8); end
      K_ER: begin send(2'b11, 2); send(32'(a), n); end
      K_EN: begin send(2'b00, 2); send(32'd3 << (n - 2), n); end
      K_DS: begin send(2'b00, 2); send(32'd0, n); end
      K_EA: begin send(2'b00, 2); send(32'd2 << (n - 2), n); end
      default: begin send(2'b00, 2); send(32'd1 << (n - 2), n); send(32'(d), o ? 16 : 8); end
    endcase
    cs_lo;
    tick(PROG + 20);
  endtask

  task automatic rd(input logic o, input logic [8:0] a, input int lead,
                    output logic [15:0] v);
    v = '0;
    org = o;
    cs_hi;
    send(32'd0, lead);
    bit_out(1'b1);
    send(2'b10, 2);
    send(32'(a), afl(o));
    chk("R3", {30'd0, doe, dout}, 32'b10, "dummy bit");
    for (int i = 0; i < (o ? 16 : 8); i++) begin
      bit_out(1'b0);
      v = {v[14:0], dout};
    end
    cs_lo;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v;
    nchk = 0; nerr = 0; done = 0;
    rst_n = 1'b0; cs = 1'b0; sk = 1'b0; di = 1'b0; org = 1'b1;
    tick(5);
    rst_n = 1'b1;
    tick(10);
    chk("R1", 32'(doe), 0, "oe after reset");
    cs_hi;
    chk("R1", 32'(doe), 0, "oe with select high after reset");
    cs_lo;

    for (int i = 0; i < NT; i++) begin
      logic [48:0] e;
      e = TBL[i];
      if (e[44:42] == K_RD) begin
        rd(e[41], e[40:32], 0, v);
        chk($sformatf("R%0d", e[48:45]), 32'(v), 32'(e[15:0]),
            $sformatf("table entry %0d", i));
      end else begin
        instr(e[41], e[44:42], e[40:32], e[31:16]);
      end
    end

    // R10 / R11: status on data out during and after a program window
    instr(1'b1, K_EN, 9'h0, 16'h0);
    org = 1'b1;
    cs_hi;
    bit_out(1'b1); send(2'b01, 2); send(32'h10, 8); send(32'hC0DE, 16);
    cs_lo;
    cs_hi;
    chk("R10", {30'd0, doe, dout}, 32'b10, "busy shown");
    cs_lo;
    chk("R10", 32'(doe), 0, "undriven with select low");
    cs_hi;
    bit_out(1'b1); bit_out(1'b1);
    chk("R11", {30'd0, doe, dout}, 32'b10, "start bit ignored while busy");
    tick(PROG);
    chk("R10", {30'd0, doe, dout}, 32'b11, "ready shown");
    bit_out(1'b1);
    chk("R11", 32'(doe), 0, "status cleared by start bit");
    cs_lo;
    rd(1'b1, 9'h010, 0, v);
    chk("R4", 32'(v), 32'hC0DE, "write without erase");

    // R2: leading zeros and abandoned frame
    rd(1'b1, 9'h010, 3, v);
    chk("R2", 32'(v), 32'hC0DE, "leading zeros ignored");
    cs_hi;
    bit_out(1'b1); send(2'b01, 2); send(32'h1, 4);
    cs_lo;
    tick(PROG + 20);
    cs_hi;
    chk("R2", 32'(doe), 0, "aborted frame starts no cycle");
    cs_lo;
    rd(1'b1, 9'h010, 0, v);
    chk("R2", 32'(v), 32'hC0DE, "aborted frame leaves memory");

    // R1: contents survive reset, gate closes on reset
    instr(1'b1, K_WA, 9'h0, 16'hBEEF);
    rst_n = 1'b0; tick(5); rst_n = 1'b1; tick(10);
    instr(1'b1, K_WR, 9'h002, 16'h0000);
    cs_hi;
    chk("R8", 32'(doe), 0, "no status for blocked write");
    cs_lo;
    rd(1'b1, 9'h002, 0, v);
    chk("R1", 32'(v), 32'hBEEF, "retained, gate closed after reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule